// File: doc/BRIEF.md
# UART Receive Descriptor Ring Engine

This block sits behind a UART receiver and moves each received character into memory buffers that are described by a ring of descriptors. Every descriptor takes eight bytes. It holds a control and status halfword, a count of stored bytes, and a 32-bit pointer to its data buffer. The engine uses a descriptor only while the host has marked it as owned by the engine. It fills the buffer one byte at a time and closes the buffer for one of three reasons: a character arrives with a reception error, the buffer reaches its configured length, or a configured number of consecutive idle character times pass. On close it writes back the byte count and the status, raises an event when the descriptor asks for one, and moves on to the next descriptor in the ring.

The descriptor is read lazily, on the first character that needs it. The table base, the maximum buffer length and the idle limit are register inputs. All descriptor and buffer traffic goes through one synchronous RAM port with halfword data and byte strobes. Read data arrives one cycle after the request. Characters and idle ticks are single-cycle pulses at UART rates, so they arrive at least 16 clock cycles apart.

Top module: `uartbd_rx_engine`

## Requirements
- R1: Descriptor n lies at `tbl_base + 8*n`, where `tbl_base` is 8-byte aligned. Within a descriptor, the status halfword is at +0, the stored-byte count at +2, and the buffer pointer at +4 (upper half) and +6 (lower half).
- R2: Status bits are numbered with 0 as the least significant bit. Bit 15 is ownership (1 = engine owns the descriptor). Bit 13 is wrap, bit 12 is event request, bit 9 is continuous mode and bit 8 is idle-closed. Bit 5 is break, bit 4 is framing, bit 3 is parity and bit 1 is overrun. All other bits are written as 0.
- R3: If a character arrives while the current descriptor has ownership 0, the character is dropped, nothing is written to memory, and `evt_busy` is set.
- R4: Byte k of a buffer is written at `pointer + k`. An even address uses strobe `2'b10` and an odd address uses strobe `2'b01`. `mem_wdata` carries the character in both byte lanes.
- R5: When the stored-byte count reaches `max_len`, the buffer closes. The count is written back and no idle or error bit is set.
- R6: `rx_err` is encoded as bit 3 break, bit 2 framing, bit 1 parity and bit 0 overrun. A character with any of these bits set is stored and then closes the buffer. The matching status flags are set and ownership is written as 0.
- R7: After at least one byte is stored, `idle_limit` consecutive `idle_tick` pulses close the buffer with idle-closed set. A character restarts the count. A limit of 0 disables idle closing. Idle ticks do nothing while no byte is stored.
- R8: On close, the count is written after the last data byte, and the status is written after the count.
- R9: After a descriptor closes, the next one is at +8. If the closed descriptor had wrap set, the next one is the descriptor at `tbl_base`.
- R10: With continuous mode set and no error, the written status keeps ownership at 1. Wrap, event request and continuous mode are written back as they were read.
- R11: Closing a descriptor whose event-request bit is set sets `evt_rx`. Events stay set until cleared through `evt_clr` (bit 0 clears rx, bit 1 clears busy). `irq` = (`evt_rx` & `int_en[0]`) | (`evt_busy` & `int_en[1]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | Byte address of the first descriptor |
| max_len | input | 16 | Buffer size in bytes |
| idle_limit | input | 16 | Idle ticks that close a buffer, 0 = off |
| rx_valid | input | 1 | Pulse: a character is available |
| rx_data | input | 8 | Received character |
| rx_err | input | 4 | Error flags that come with the character |
| idle_tick | input | 1 | Pulse: one idle character time elapsed |
| int_en | input | 2 | Interrupt enables {busy, rx} |
| evt_clr | input | 2 | Event clear pulses {busy, rx} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_wstrb | output | 2 | Byte strobes {even byte, odd byte} |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| evt_rx | output | 1 | Buffer-closed event |
| evt_busy | output | 1 | Dropped-character event |
| irq | output | 1 | Interrupt output |

## Verification
The hardest situation to reach is the idle close: the counter must restart when a character arrives between ticks, and it must not act on an empty buffer or when the limit is 0. The stimulus interleaves characters with idle ticks that stop one short of the limit. It sends ticks before any descriptor is loaded, and it sets the limit to 0 on a partly filled buffer. Any early close shows up as an unexpected memory write against the scoreboard queue. Ownership refusal is reached by letting the ring wrap back to a descriptor that the engine itself closed. The bench then hands that descriptor back and checks that the next character fills it.

// File: rtl/uartbd_pkg.sv
package uartbd_pkg;

    localparam int ADDR_W = 32;

    // status bit positions, bit 0 = least significant
    localparam int B_OWN  = 15;
    localparam int B_WRAP = 13;
    localparam int B_INT  = 12;
    localparam int B_CONT = 9;
    localparam int B_IDLE = 8;
    localparam int B_BRK  = 5;
    localparam int B_FRM  = 4;
    localparam int B_PAR  = 3;
    localparam int B_OVR  = 1;
    localparam logic [15:0] RSVD_MASK = 16'h4CC5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_STORE, ST_WLEN, ST_WST
    } bd_state_e;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rx_err_t;

    typedef struct packed {
        logic wrap;
        logic intr;
        logic cont;
    } bd_ctl_t;

    function automatic logic [15:0] pack_status(logic own, bd_ctl_t c,
                                                logic idle_cl, rx_err_t e);
        logic [15:0] s;
        s = '0;
        s[B_OWN]  = own;
        s[B_WRAP] = c.wrap;
        s[B_INT]  = c.intr;
        s[B_CONT] = c.cont;
        s[B_IDLE] = idle_cl;
        s[B_BRK]  = e.brk;
        s[B_FRM]  = e.frm;
        s[B_PAR]  = e.par;
        s[B_OVR]  = e.ovr;
        return s;
    endfunction

endpackage

// File: rtl/uartbd_rxhold.sv
module uartbd_rxhold
    import uartbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  rx_err_t    rx_err,
    input  logic       consume,
    output logic       pend_v,
    output logic [7:0] pend_d,
    output rx_err_t    pend_e
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_d <= '0;
            pend_e <= '0;
        end else if (rx_valid) begin
            pend_v <= 1'b1;
            pend_d <= rx_data;
            pend_e <= rx_err;
        end else if (consume) begin
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/uartbd_idle.sv
module uartbd_idle #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDLE_W-1:0] limit,
    input  logic              armed,
    input  logic              tick,
    input  logic              rx_seen,
    input  logic              clr,
    output logic              hit
);
    logic [IDLE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || rx_seen) begin
            cnt <= '0;
        end else if (tick && armed && cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = armed && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/uartbd_events.sv
module uartbd_events (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_rx,
    input  logic       set_busy,
    input  logic [1:0] clr,
    input  logic [1:0] en,
    output logic       evt_rx,
    output logic       evt_busy,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_rx   <= 1'b0;
            evt_busy <= 1'b0;
        end else begin
            if (set_rx)      evt_rx <= 1'b1;
            else if (clr[0]) evt_rx <= 1'b0;
            if (set_busy)    evt_busy <= 1'b1;
            else if (clr[1]) evt_busy <= 1'b0;
        end
    end

    assign irq = (evt_rx && en[0]) || (evt_busy && en[1]);
endmodule

// File: rtl/uartbd_ctrl.sv
module uartbd_ctrl
    import uartbd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              pend_v,
    input  logic [7:0]        pend_d,
    input  rx_err_t           pend_e,
    input  logic              idle_hit,
    input  logic [15:0]       mem_rdata,
    output logic              consume,
    output logic              armed,
    output logic              close_now,
    output logic              set_rx,
    output logic              set_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_wstrb
);
    localparam logic [ADDR_W-1:0] BD_STEP = ADDR_W'(8);

    bd_state_e         state;
    logic [ADDR_W-1:0] bd_off;
    logic              loaded;
    bd_ctl_t           ctl;
    logic [15:0]       ptr_hi;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  len;
    rx_err_t           cl_err;
    logic              cl_idle;

    logic [ADDR_W-1:0] bd_addr;
    logic [ADDR_W-1:0] byte_addr;
    logic              owned;
    logic [LEN_W-1:0]  len_nx;

    assign bd_addr   = tbl_base + bd_off;
    assign byte_addr = ptr + ADDR_W'(len);
    assign owned     = mem_rdata[B_OWN];
    assign len_nx    = len + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bd_off  <= '0;
            loaded  <= 1'b0;
            ctl     <= '0;
            ptr_hi  <= '0;
            ptr     <= '0;
            len     <= '0;
            cl_err  <= '0;
            cl_idle <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend_v) begin
                        state <= loaded ? ST_STORE : ST_F0;
                    end else if (idle_hit) begin
                        cl_idle <= 1'b1;
                        state   <= ST_WLEN;
                    end
                end
                ST_F0: state <= ST_F1;
                ST_F1: begin
                    if (owned) begin
                        ctl   <= '{wrap: mem_rdata[B_WRAP], intr: mem_rdata[B_INT],
                                   cont: mem_rdata[B_CONT]};
                        state <= ST_F2;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_F2: begin
                    ptr_hi <= mem_rdata;
                    state  <= ST_F3;
                end
                ST_F3: begin
                    ptr    <= ADDR_W'({ptr_hi, mem_rdata});
                    len    <= '0;
                    loaded <= 1'b1;
                    state  <= ST_STORE;
                end
                ST_STORE: begin
                    len <= len_nx;
                    if (pend_e != '0) begin
                        cl_err <= pend_e;
                        state  <= ST_WLEN;
                    end else if (len_nx == max_len) begin
                        state <= ST_WLEN;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_WLEN: state <= ST_WST;
                ST_WST: begin
                    bd_off  <= ctl.wrap ? '0 : bd_off + BD_STEP;
                    loaded  <= 1'b0;
                    cl_err  <= '0;
                    cl_idle <= 1'b0;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = bd_addr;
        mem_wdata = '0;
        mem_wstrb = 2'b00;
        unique case (state)
            ST_F0: mem_req = 1'b1;
            ST_F1: begin
                mem_req  = owned;
                mem_addr = bd_addr + ADDR_W'(4);
            end
            ST_F2: begin
                mem_req  = 1'b1;
                mem_addr = bd_addr + ADDR_W'(6);
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = byte_addr;
                mem_wdata = {pend_d, pend_d};
                mem_wstrb = byte_addr[0] ? 2'b01 : 2'b10;
            end
            ST_WLEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = bd_addr + ADDR_W'(2);
                mem_wdata = 16'(len);
                mem_wstrb = 2'b11;
            end
            ST_WST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = pack_status(ctl.cont && (cl_err == '0), ctl, cl_idle, cl_err);
                mem_wstrb = 2'b11;
            end
            default: ;
        endcase
    end

    assign consume   = (state == ST_STORE) || (state == ST_F1 && !owned);
    assign set_busy  = (state == ST_F1) && !owned;
    assign set_rx    = (state == ST_WST) && ctl.intr;
    assign close_now = (state == ST_WST);
    assign armed     = loaded && (len != '0);
endmodule

// File: rtl/uartbd_rx_engine.sv
module uartbd_rx_engine
    import uartbd_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [3:0]        rx_err,
    input  logic              idle_tick,
    input  logic [1:0]        int_en,
    input  logic [1:0]        evt_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_wstrb,
    input  logic [15:0]       mem_rdata,
    output logic              evt_rx,
    output logic              evt_busy,
    output logic              irq
);
    logic       pend_v;
    logic [7:0] pend_d;
    rx_err_t    pend_e;
    logic       consume, armed, close_now, idle_hit, set_rx, set_busy;

    uartbd_rxhold u_hold (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err_t'(rx_err)), .consume(consume),
        .pend_v(pend_v), .pend_d(pend_d), .pend_e(pend_e)
    );

    uartbd_idle #(.IDLE_W(IDLE_W)) u_idle (
        .clk(clk), .rst(rst), .limit(idle_limit), .armed(armed),
        .tick(idle_tick), .rx_seen(rx_valid), .clr(close_now), .hit(idle_hit)
    );

    uartbd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .max_len(max_len),
        .pend_v(pend_v), .pend_d(pend_d), .pend_e(pend_e), .idle_hit(idle_hit),
        .mem_rdata(mem_rdata), .consume(consume), .armed(armed),
        .close_now(close_now), .set_rx(set_rx), .set_busy(set_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
    );

    uartbd_events u_evt (
        .clk(clk), .rst(rst), .set_rx(set_rx), .set_busy(set_busy),
        .clr(evt_clr), .en(int_en), .evt_rx(evt_rx), .evt_busy(evt_busy), .irq(irq)
    );
endmodule

// File: rtl/uartbd_chk.sv
module uartbd_chk
    import uartbd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic [1:0]        mem_wstrb,
    input logic [LEN_W-1:0]  max_len,
    input logic [1:0]        int_en,
    input logic [1:0]        evt_clr,
    input logic              evt_rx,
    input logic              evt_busy,
    input logic              irq
);
    logic st_wr, len_wr, any_err;
    assign st_wr   = mem_req && mem_we && mem_wstrb == 2'b11 && mem_addr[2:0] == 3'd0;
    assign len_wr  = mem_req && mem_we && mem_wstrb == 2'b11 && mem_addr[2:0] == 3'd2;
    assign any_err = mem_wdata[B_BRK] || mem_wdata[B_FRM] || mem_wdata[B_PAR] || mem_wdata[B_OVR];

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_wr |-> (mem_wdata & RSVD_MASK) == 16'h0000); // R2
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        len_wr |-> (mem_wdata != 16'h0000) && (max_len == '0 || mem_wdata <= 16'(max_len))); // R5
    AST_ERR_OWN: assert property (@(posedge clk) disable iff (rst)
        (st_wr && any_err) |-> !mem_wdata[B_OWN]); // R6
    AST_IDLE_NOERR: assert property (@(posedge clk) disable iff (rst)
        (st_wr && mem_wdata[B_IDLE]) |-> !any_err); // R7
    AST_LEN_FIRST: assert property (@(posedge clk) disable iff (rst)
        st_wr |-> $past(len_wr)); // R8
    AST_BYTE_STRB: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_wstrb != 2'b11) |-> $onehot0(mem_wstrb) && mem_wstrb == (mem_addr[0] ? 2'b01 : 2'b10)); // R4
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt_rx && !evt_clr[0]) |=> evt_rx); // R11
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((evt_rx && int_en[0]) || (evt_busy && int_en[1]))); // R11
endmodule

bind uartbd_rx_engine uartbd_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .max_len(max_len),
    .int_en(int_en), .evt_clr(evt_clr), .evt_rx(evt_rx), .evt_busy(evt_busy), .irq(irq)
);

// File: tb/tb_uartbd_rx_engine.sv
module tb_uartbd_rx_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tbl_base = 32'h0000_0100;
    logic [15:0] max_len = 16'd4;
    logic [15:0] idle_limit = 16'd3;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [3:0]  rx_err = '0;
    logic        idle_tick = 1'b0;
    logic [1:0]  int_en = 2'b11;
    logic [1:0]  evt_clr = 2'b00;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_wstrb;
    logic [15:0] mem_rdata = '0;
    logic        evt_rx, evt_busy, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] mem [0:511];

    typedef struct {
        logic [31:0] addr;
        logic [15:0] data;
        logic [1:0]  strb;
        string       tag;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #2.5 clk = ~clk;

    uartbd_rx_engine dut (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .max_len(max_len),
        .idle_limit(idle_limit), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .idle_tick(idle_tick), .int_en(int_en), .evt_clr(evt_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
        .evt_rx(evt_rx), .evt_busy(evt_busy), .irq(irq)
    );

    // memory model
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:1]];
        if (mem_req && mem_we) begin
            if (mem_wstrb[1]) mem[mem_addr[9:1]][15:8] <= mem_wdata[15:8];
            if (mem_wstrb[0]) mem[mem_addr[9:1]][7:0]  <= mem_wdata[7:0];
        end
    end

    // monitor: every write must match the next expected item
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected write (R3/R7): act addr=%h data=%h strb=%b exp none",
                         mem_addr, mem_wdata, mem_wstrb);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (mem_addr !== e.addr || mem_wdata !== e.data || mem_wstrb !== e.strb) begin
                    bad++;
                    $display("FAIL %s: act addr=%h data=%h strb=%b exp addr=%h data=%h strb=%b",
                             e.tag, mem_addr, mem_wdata, mem_wstrb, e.addr, e.data, e.strb);
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [31:0] a, logic [15:0] v);
        mem[a[9:1]] = v;
    endtask

    task automatic exp_byte(logic [31:0] a, logic [7:0] d, string tag);
        wr_item_t e;
        e.addr = a; e.data = {d, d}; e.strb = a[0] ? 2'b01 : 2'b10; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic exp_close(logic [31:0] bd, logic [15:0] n, logic [15:0] st, string tag);
        wr_item_t e;
        e.addr = bd + 2; e.data = n; e.strb = 2'b11; e.tag = {tag, " length"};
        exp_q.push_back(e);
        e.addr = bd; e.data = st; e.strb = 2'b11; e.tag = {tag, " status"};
        exp_q.push_back(e);
    endtask

    task automatic send(logic [7:0] d, logic [3:0] e);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_err = '0;
        repeat (20) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        idle_tick = 1'b1;
        @(negedge clk);
        idle_tick = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic clr_evt(logic [1:0] c);
        @(negedge clk);
        evt_clr = c;
        @(negedge clk);
        evt_clr = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        // ring of three descriptors (R1)
        hw(32'h100, 16'h9000); hw(32'h104, 16'h0000); hw(32'h106, 16'h0200);
        hw(32'h108, 16'h8200); hw(32'h10C, 16'h0000); hw(32'h10E, 16'h0240);
        hw(32'h110, 16'hB000); hw(32'h114, 16'h0000); hw(32'h116, 16'h0280);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset evt_rx R11", evt_rx, 0);
        check("reset evt_busy R3", evt_busy, 0);
        check("reset irq R11", irq, 0);
        check("reset mem_req", mem_req, 0);

        // A: fill to max_len, event request set (R1 R4 R5 R8 R11)
        for (int i = 0; i < 4; i++) exp_byte(32'h200 + i, 8'hA0 + 8'(i), "R4 bytes desc0");
        exp_close(32'h100, 16'd4, 16'h1000, "R5 full desc0");
        for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i), 4'h0);
        check("R11 evt_rx after close with event request", evt_rx, 1);
        check("R11 irq enabled", irq, 1);
        int_en = 2'b00; @(negedge clk);
        check("R11 irq masked", irq, 0);
        clr_evt(2'b01);
        check("R11 evt_rx cleared", evt_rx, 0);

        // B: idle close, counter restarts on character, continuous mode (R7 R9 R10)
        exp_byte(32'h240, 8'h11, "R9 desc1 at +8");
        exp_byte(32'h241, 8'h12, "R4 odd lane");
        exp_byte(32'h242, 8'h13, "R7 byte after restart");
        exp_close(32'h108, 16'd3, 16'h8300, "R7 R10 idle close");
        send(8'h11, 4'h0);
        send(8'h12, 4'h0);
        tick(); tick();
        send(8'h13, 4'h0);
        tick(); tick();
        check("R7 no close before limit", exp_q.size(), 2);
        tick();
        check("R7 idle close done", exp_q.size(), 0);
        check("R11 evt_rx stays 0 without event request", evt_rx, 0);

        // C: framing error closes, wrap bit set (R6 R9)
        exp_byte(32'h280, 8'h5A, "R6 error char stored");
        exp_close(32'h110, 16'd1, 16'h3010, "R6 error close desc2");
        send(8'h5A, 4'b0100);
        check("R11 evt_rx after desc2", evt_rx, 1);
        clr_evt(2'b01);

        // D: wrapped back to desc0, owned by host -> drop (R3 R9)
        send(8'hEE, 4'h0);
        check("R3 busy event on drop", evt_busy, 1);
        check("R3 no write on drop", exp_q.size(), 0);
        int_en = 2'b10; @(negedge clk);
        check("R11 irq from busy", irq, 1);
        clr_evt(2'b10);
        check("R11 busy cleared", evt_busy, 0);
        check("R11 irq low after clear", irq, 0);

        // E: desc0 handed back; idle ticks with nothing stored, limit 0 (R7 R9)
        hw(32'h100, 16'h8000);
        tick(); tick(); tick(); tick();
        exp_byte(32'h200, 8'h61, "R9 wrap to base");
        send(8'h61, 4'h0);
        idle_limit = 16'd0;
        tick(); tick(); tick(); tick(); tick();
        check("R7 limit zero no close", exp_q.size(), 0);
        exp_byte(32'h201, 8'h62, "R4 byte1");
        exp_byte(32'h202, 8'h63, "R4 byte2");
        exp_byte(32'h203, 8'h64, "R4 byte3");
        exp_close(32'h100, 16'd4, 16'h0000, "R5 full no flags");
        send(8'h62, 4'h0); send(8'h63, 4'h0); send(8'h64, 4'h0);
        idle_limit = 16'd3;

        // F: continuous mode with parity error clears ownership (R6 R10)
        exp_byte(32'h240, 8'h77, "R6 parity char stored");
        exp_close(32'h108, 16'd1, 16'h0208, "R6 R10 error beats continuous");
        send(8'h77, 4'b0010);
        check("R8 all expected writes seen", exp_q.size(), 0);
        check("R2 stored status desc1", mem[32'h108 >> 1], 16'h0208);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule